// File: doc/BRIEF.md
# JTAG-to-SPI Bridge

This block hangs off a user data register of a JTAG TAP and converts one data-register shift into one SPI transaction, framed by a single chip select, towards a serial flash. The host shifts a stream into TDI. Zeros that come first are skipped. The first 1 opens a frame. The next 32 bits give the transaction length. Every bit after that is a payload bit. Each payload bit is driven onto MOSI with one SPI clock, and the flash's reply is handed back on TDO one bit slot later.

All state is clocked by TCK. SCLK is TCK gated by the payload enable and inverted, so the SPI link runs in mode 0. MOSI is updated on the rising TCK edge. SCLK rises half a cycle later, and MISO is sampled on that SCLK rise. Any end of the shift (shift low, select low, capture or update) drops the frame and returns the header parser to its start. A partly shifted transaction therefore never leaves the flash selected.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While reset is high, and on the first rising TCK edge after it, CS_n is 1 and SCLK, MOSI and TDO are 0.
- R2: While the shift is live (select and shift high, capture and update low), TDI zeros are ignored until the first 1. That 1 is the start marker. It produces no SPI clock and does not appear on MOSI.
- R3: The 32 TDI bits after the marker are a length value N, first bit most significant. The frame then carries exactly N+1 payload bits and N+1 SCLK pulses.
- R4: CS_n goes low on the rising TCK edge that samples the first payload bit. It stays low until the rising edge after the one that samples the last payload bit, and is 1 at all other times.
- R5: On the rising edge that samples a payload bit, MOSI takes that TDI value and holds it for one TCK cycle. SCLK is high during the low phase of that cycle only, which gives SPI mode 0. Bits shifted in as zeros go out as zeros.
- R6: MISO is sampled on the falling TCK edge of payload bit k. That value is driven on TDO from the rising edge that samples the following TDI bit, which gives a one-bit skip between the MOSI slot and the TDO slot.
- R7: If the shift is not live at a rising TCK edge, that edge deselects the flash, stops SCLK and returns the parser to marker search. The next live shift starts a new frame from its own marker.
- R8: After the counted bits, further live shift bits, 1s included, give no SCLK, keep CS_n high and MOSI 0, and open no new frame until the shift ends.
- R9: TDO is 0 except in the TDO slot that carries a returned MISO bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock; clocks all state |
| rst | input | 1 | Synchronous active-high reset |
| jtag_sel | input | 1 | User data register is selected |
| jtag_shift | input | 1 | TAP is in the shift-DR state |
| jtag_capture | input | 1 | Capture-DR event |
| jtag_update | input | 1 | Update-DR event |
| jtag_tdi | input | 1 | Serial data from the host |
| jtag_tdo | output | 1 | Serial data to the host (returned MISO) |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
If the parser is in the wrong phase, CS_n falls on the wrong TCK edge or the frame carries the wrong number of SCLK pulses. Either shows at the ports within one bit slot of the marker or of the last counted bit. If the length is decoded wrong, the frame ends early or late, and the per-frame SCLK count exposes it. Stale state after an abort shows on the very next shift, when the new marker fails to open a clean frame. A misplaced MISO register shifts every returned bit by one TDO slot, which the bit-by-bit TDO comparison catches on the first payload bit after the first one.

// File: rtl/jsb_pkg.sv
package jsb_pkg;

    localparam int unsigned HDR_BITS = 32;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LEN  = 2'd1,
        ST_PAY  = 2'd2,
        ST_DONE = 2'd3
    } frame_st_e;

    typedef struct packed {
        logic en;
        logic mosi;
    } lane_t;

    function automatic logic shift_live(input logic sel, input logic shift,
                                        input logic cap, input logic upd);
        return sel & shift & ~cap & ~upd;
    endfunction

endpackage

// File: rtl/jsb_frame.sv
module jsb_frame
    import jsb_pkg::*;
#(
    parameter int unsigned CNT_W = HDR_BITS
) (
    input  logic tck,
    input  logic rst,
    input  logic live,
    input  logic tdi,
    output logic take
);
    localparam int unsigned IDX_W = $clog2(CNT_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CNT_W - 1);

    frame_st_e        st_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] len_nx;

    assign len_nx = {len_q[CNT_W-2:0], tdi};
    assign take   = live && (st_q == ST_PAY);

    always_ff @(posedge tck) begin
        if (rst || !live) begin
            st_q   <= ST_HUNT;
            idx_q  <= '0;
            len_q  <= '0;
            left_q <= '0;
        end else begin
            unique case (st_q)
                ST_HUNT: begin
                    if (tdi) begin
                        st_q  <= ST_LEN;
                        idx_q <= '0;
                    end
                end
                ST_LEN: begin
                    len_q <= len_nx;
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) begin
                        st_q   <= ST_PAY;
                        left_q <= len_nx;
                    end
                end
                ST_PAY: begin
                    left_q <= left_q - 1'b1;
                    if (left_q == '0) st_q <= ST_DONE;
                end
                default: st_q <= ST_DONE;
            endcase
        end
    end
endmodule

// File: rtl/jsb_wire.sv
module jsb_wire
    import jsb_pkg::*;
(
    input  logic tck,
    input  logic rst,
    input  logic live,
    input  logic take,
    input  logic tdi,
    input  logic spi_miso,
    output logic spi_sclk,
    output logic spi_cs_n,
    output logic spi_mosi,
    output logic tdo
);
    lane_t lane_q;
    logic  miso_s;
    logic  tdo_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            lane_q <= '0;
            tdo_q  <= 1'b0;
        end else begin
            lane_q.en   <= take;
            lane_q.mosi <= take & tdi;
            tdo_q       <= live & lane_q.en & miso_s;
        end
    end

    always_ff @(negedge tck) begin
        miso_s <= spi_miso;
    end

    assign spi_sclk = lane_q.en & ~tck;
    assign spi_cs_n = ~lane_q.en;
    assign spi_mosi = lane_q.mosi;
    assign tdo      = tdo_q;
endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
    import jsb_pkg::*;
#(
    parameter int unsigned CNT_W = HDR_BITS
) (
    input  logic tck,
    input  logic rst,
    input  logic jtag_sel,
    input  logic jtag_shift,
    input  logic jtag_capture,
    input  logic jtag_update,
    input  logic jtag_tdi,
    output logic jtag_tdo,
    output logic spi_sclk,
    output logic spi_cs_n,
    output logic spi_mosi,
    input  logic spi_miso
);
    logic live;
    logic take;

    assign live = shift_live(jtag_sel, jtag_shift, jtag_capture, jtag_update);

    jsb_frame #(.CNT_W(CNT_W)) u_frame (
        .tck  (tck),
        .rst  (rst),
        .live (live),
        .tdi  (jtag_tdi),
        .take (take)
    );

    jsb_wire u_wire (
        .tck      (tck),
        .rst      (rst),
        .live     (live),
        .take     (take),
        .tdi      (jtag_tdi),
        .spi_miso (spi_miso),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .tdo      (jtag_tdo)
    );
endmodule

// File: rtl/jsb_chk.sv
module jsb_chk (
    input logic tck,
    input logic rst,
    input logic jtag_sel,
    input logic jtag_shift,
    input logic jtag_capture,
    input logic jtag_update,
    input logic jtag_tdi,
    input logic jtag_tdo,
    input logic spi_cs_n,
    input logic spi_mosi
);
    // R7
    abort_deselect_chk: assert property (@(posedge tck) disable iff (rst)
        !(jtag_sel && jtag_shift && !jtag_capture && !jtag_update) |=> spi_cs_n);

    // R5
    mosi_quiet_chk: assert property (@(posedge tck) disable iff (rst)
        spi_cs_n |-> !spi_mosi);

    // R5
    mosi_follows_chk: assert property (@(posedge tck) disable iff (rst)
        !spi_cs_n |-> (spi_mosi == $past(jtag_tdi)));

    // R9
    tdo_idle_chk: assert property (@(posedge tck) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n)) |-> !jtag_tdo);

    // R4
    frame_in_shift_chk: assert property (@(posedge tck) disable iff (rst)
        $fell(spi_cs_n) |-> $past(jtag_sel && jtag_shift));
endmodule

bind jtag_spi_bridge jsb_chk u_chk (
    .tck          (tck),
    .rst          (rst),
    .jtag_sel     (jtag_sel),
    .jtag_shift   (jtag_shift),
    .jtag_capture (jtag_capture),
    .jtag_update  (jtag_update),
    .jtag_tdi     (jtag_tdi),
    .jtag_tdo     (jtag_tdo),
    .spi_cs_n     (spi_cs_n),
    .spi_mosi     (spi_mosi)
);

// File: tb/tb_jtag_spi_bridge.sv
module tb_jtag_spi_bridge;
    logic tck = 1'b0;
    logic rst = 1'b1;
    logic jtag_sel = 1'b0, jtag_shift = 1'b0, jtag_capture = 1'b0, jtag_update = 1'b0;
    logic jtag_tdi = 1'b0, spi_miso = 1'b0;
    logic jtag_tdo, spi_sclk, spi_cs_n, spi_mosi;

    int n_chk = 0, n_fail = 0, pulses = 0;
    logic prev_pay = 1'b0, prev_miso = 1'b0;

    always #5 tck = ~tck;

    jtag_spi_bridge dut (
        .tck(tck), .rst(rst), .jtag_sel(jtag_sel), .jtag_shift(jtag_shift),
        .jtag_capture(jtag_capture), .jtag_update(jtag_update),
        .jtag_tdi(jtag_tdi), .jtag_tdo(jtag_tdo), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic live_now();
        return jtag_sel & jtag_shift & ~jtag_capture & ~jtag_update;
    endfunction

    // One TCK slot: called just after a falling edge.
    task automatic step(input logic tdi_v, input logic miso_v, input logic is_pay,
                        input string req);
        logic exp_tdo;
        jtag_tdi = tdi_v;
        exp_tdo = live_now() & prev_pay & prev_miso;
        @(posedge tck); #1;
        chk({req, " cs_n"}, spi_cs_n, !is_pay);
        chk({req, " mosi"}, spi_mosi, is_pay & tdi_v);
        chk("R6/R9 tdo", jtag_tdo, exp_tdo);
        chk({req, " sclk high phase"}, spi_sclk, 1'b0);
        spi_miso = miso_v;
        @(negedge tck); #1;
        chk("R5 sclk low phase", spi_sclk, is_pay);
        if (spi_sclk) pulses++;
        prev_pay  = is_pay;
        prev_miso = miso_v;
    endtask

    task automatic header(input int lead, input logic [31:0] n);
        jtag_sel = 1'b1; jtag_shift = 1'b1;
        for (int i = 0; i < lead; i++) step(1'b0, 1'b1, 1'b0, "R2 lead");
        step(1'b1, 1'b1, 1'b0, "R2 marker");
        for (int i = 31; i >= 0; i--) step(n[i], 1'b1, 1'b0, "R3 length");
    endtask

    task automatic end_shift();
        jtag_shift = 1'b0;
        step(1'b1, 1'b0, 1'b0, "R7 end");
    endtask

    task automatic frame(input int lead, input logic [31:0] n, input int extra);
        header(lead, n);
        pulses = 0;
        for (int unsigned i = 0; i <= n; i++)
            step(1'($urandom), 1'($urandom), 1'b1, "R4/R5 payload");
        chk("R3 sclk pulse count", pulses, n + 1);
        for (int i = 0; i < extra; i++) step(1'b1, 1'b1, 1'b0, "R8 after count");
        end_shift();
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge tck);
        #1;
        chk("R1 reset cs_n", spi_cs_n, 1'b1);
        chk("R1 reset mosi", spi_mosi, 1'b0);
        chk("R1 reset tdo", jtag_tdo, 1'b0);
        chk("R1 reset sclk", spi_sclk, 1'b0);
        @(negedge tck); #1;
        rst = 1'b0;
        step(1'b1, 1'b1, 1'b0, "R1 idle no shift");

        // Directed: single-bit, one byte, long frame with trailing ones.
        frame(0, 32'd0, 2);
        frame(3, 32'd7, 4);
        frame(1, 32'd299, 3);

        // R7: abort by shift low mid-payload, then a fresh frame.
        header(2, 32'd20);
        for (int i = 0; i < 5; i++) step(1'($urandom), 1'($urandom), 1'b1, "R4 pre-abort");
        end_shift();
        frame(1, 32'd3, 1);

        // R7: abort by capture pulse.
        header(0, 32'd15);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, "R5 pre-capture");
        jtag_capture = 1'b1;
        step(1'b1, 1'b1, 1'b0, "R7 capture abort");
        jtag_capture = 1'b0;
        frame(0, 32'd1, 1);

        // R7: abort by update and by deselect.
        header(0, 32'd9);
        step(1'b0, 1'b1, 1'b1, "R5 pre-update");
        jtag_update = 1'b1;
        step(1'b1, 1'b1, 1'b0, "R7 update abort");
        jtag_update = 1'b0;
        header(0, 32'd9);
        step(1'b1, 1'b0, 1'b1, "R5 pre-deselect");
        jtag_sel = 1'b0;
        step(1'b1, 1'b1, 1'b0, "R7 deselect abort");
        end_shift();

        // Random frames.
        for (int f = 0; f < 24; f++)
            frame($urandom_range(0, 3), 32'($urandom_range(0, 40)), $urandom_range(0, 3));

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule